// File: doc/BRIEF.md
# IOM-2 Command/Indicate Channel Monitor

This block terminates the two Command/Indicate (C/I) fields of a terminal-mode IOM-2 frame: one in the first subframe and one in the second. It runs on the data clock, one frame bit per clock. The frame is opened by a one-cycle frame sync pulse. It samples the downstream data line during each C/I slot and drives the upstream line in the same slots.

A received code is not taken at once. It must differ from the code that is currently accepted, and it must then arrive unchanged in two frames in a row. Only then is it stored and an interrupt raised. Each subframe has its own filter, its own accepted code and its own sticky flag. Software reads the accepted codes and writes the upstream codes through a small synchronous register port. When bus arbitration is enabled, a request bit in the first transmit register decides whether the first C/I code reaches the line at all. Every upstream bit that the block does not drive is left high, which is the idle level of an open-drain line.

Register map (8-bit data, 2-bit address):
- Address 0 holds the accepted code of subframe 0 in bits 3:0. It is read-only and reads zero above.
- Address 1 holds the accepted code of subframe 1 in bits 5:0. It is read-only and reads zero above.
- Address 2 is transmit register 0. Bits 3:0 are the upstream code and bit 7 is the access request. All 8 bits are stored and read back.
- Address 3 is transmit register 1. Bits 5:0 are the upstream code. All 8 bits are stored and read back.

Top module: `cim_ci_monitor`

## Requirements
- R1: After reset, irq is 0 and dout is 1. The four registers read 0x0F, 0x3F, 0x0F and 0x3F at addresses 0 to 3.
- R2: Frame bit 0 is the cycle in which fsync is 1, and a frame is 96 bits, MSB first within each byte. C/I code 0 is carried on frame bits 26..29, with bit 3 of the code first. C/I code 1 is carried on frame bits 56..61, with bit 5 of the code first. The din value on all other bits never changes a received code.
- R3: A received code that differs from the accepted one replaces it only after it has been seen in two consecutive frames. A code seen in only one frame leaves the read value unchanged and raises no interrupt.
- R4: When a different non-accepted code arrives while a candidate is pending, the count restarts with the new code. The sequence A,B,B accepts B. The sequence A,B,A accepts nothing, and a further A then accepts A.
- R5: The two subframes are filtered independently, and each sets only its own flag. Reading address 0 does not clear the flag of subframe 1.
- R6: irq is the OR of the two sticky flags. A flag stays set across further frames until its receive register (address 0 or 1) is read, and that read clears it.
- R7: A frame that carries the accepted code cancels a pending candidate. A code equal to the accepted one never raises an interrupt.
- R8: Transmit register 0 bits 3:0 are driven on frame bits 26..29, and transmit register 1 bits 5:0 on frame bits 56..61, MSB first. Transmit registers read back as written. Writes to addresses 0 and 1 are ignored.
- R9: When tic_en is 1, C/I code 0 is driven only while bit 7 of transmit register 0 is 1. Otherwise dout stays 1 in that slot. C/I code 1 is not affected.
- R10: dout is 1 on every bit outside the two C/I slots. It is also 1 after the 96th bit until the next fsync, and nothing received in that gap counts as a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | data clock, one frame bit per cycle |
| rst | input | 1 | synchronous active-high reset |
| fsync | input | 1 | frame sync, high during frame bit 0 |
| din | input | 1 | data downstream |
| dout | output | 1 | data upstream, 1 when not driven |
| tic_en | input | 1 | enables gating of C/I 0 by the request bit |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (clears the receive flag) |
| reg_addr | input | 2 | register address |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data for reg_addr, combinational |
| irq | output | 1 | OR of the two sticky change flags |

## Verification
The assertions assume that fsync is a single-cycle pulse at the start of a frame. They also assume that a read of a receive register never falls on the last bit of that subframe's C/I slot, because there a newly accepted code and a clear would meet. The bench issues all register accesses in the gap after the 96th bit, where the timer is idle, so that case cannot arise. In the gap the bench holds din at patterns that would count as a code if the gap were taken for a frame.

// File: rtl/cim_pkg.sv
`timescale 1ns/1ps
package cim_pkg;

    localparam int FRAME_BYTES   = 12;
    localparam int FRAME_BITS    = FRAME_BYTES * 8;
    localparam int POS_W         = $clog2(FRAME_BITS + 1);
    localparam int NUM_CI        = 2;
    localparam int CI_MAX        = 6;
    localparam int STABLE_FRAMES = 2;
    localparam int REG_W         = 8;
    localparam int TX_REQ_BIT    = 7;
    localparam int GATED_CH      = 0;

    typedef enum logic [1:0] {
        RA_RX0 = 2'd0,
        RA_RX1 = 2'd1,
        RA_TX0 = 2'd2,
        RA_TX1 = 2'd3
    } reg_addr_e;

    // Frame position seen by all slot logic.
    typedef struct packed {
        logic             active;
        logic [POS_W-1:0] pos;
    } slot_pos_t;

    function automatic int ci_width(input int ch);
        return (ch == 0) ? 4 : 6;
    endfunction

    // First frame bit of each C/I slot: byte 3 bit 2, byte 7 bit 0.
    function automatic int ci_first(input int ch);
        return (ch == 0) ? (3 * 8 + 2) : (7 * 8);
    endfunction

    function automatic logic [CI_MAX-1:0] ci_mask(input int ch);
        return CI_MAX'((1 << ci_width(ch)) - 1);
    endfunction

endpackage

// File: rtl/cim_frame_timer.sv
`timescale 1ns/1ps
module cim_frame_timer
    import cim_pkg::*;
#(
    parameter int FBITS = FRAME_BITS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fsync,
    output slot_pos_t tpos
);
    localparam int PW = $clog2(FBITS + 1);
    localparam logic [PW-1:0] IDLE = PW'(FBITS);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] cnt_d;

    always_comb begin
        if (fsync)
            cnt_d = '0;
        else if (cnt_q == IDLE)
            cnt_d = IDLE;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= IDLE;
        else
            cnt_q <= cnt_d;
    end

    assign tpos.active = (cnt_d != IDLE);
    assign tpos.pos    = POS_W'(cnt_d);

    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        (!fsync && tpos.active) |-> (tpos.pos == $past(tpos.pos) + 1'b1)) // R2
        else $error("frame position did not advance by one");

    AST_SYNC_OPENS: assert property (@(posedge clk) disable iff (rst)
        $past(fsync) |-> (cnt_q == '0)) // R2
        else $error("sync did not open a frame");

endmodule

// File: rtl/cim_rx_filter.sv
`timescale 1ns/1ps
module cim_rx_filter
    import cim_pkg::*;
#(
    parameter int W      = 4,
    parameter int FIRST  = 26,
    parameter int STABLE = STABLE_FRAMES
) (
    input  logic         clk,
    input  logic         rst,
    input  slot_pos_t    tpos,
    input  logic         din,
    input  logic         rd_clr,
    output logic [W-1:0] stored,
    output logic         flag
);
    localparam int MW = $clog2(STABLE + 1);
    localparam logic [POS_W-1:0] P_FIRST = POS_W'(FIRST);
    localparam logic [POS_W-1:0] P_LAST  = POS_W'(FIRST + W - 1);

    logic [W-2:0]  sh;
    logic [W-1:0]  code_now;
    logic [W-1:0]  cand;
    logic [MW-1:0] mcnt;
    logic [MW-1:0] nxt_cnt;
    logic          in_slot;
    logic          slot_end;
    logic          hit;
    logic          accept;
    logic          differ;

    assign in_slot  = tpos.active && (tpos.pos >= P_FIRST) && (tpos.pos <= P_LAST);
    assign slot_end = tpos.active && (tpos.pos == P_LAST);
    assign code_now = {sh, din};
    assign differ   = (code_now != stored);
    assign hit      = (mcnt != '0) && (code_now == cand);

    always_comb begin
        accept  = 1'b0;
        nxt_cnt = mcnt;
        if (slot_end) begin
            if (!differ) begin
                nxt_cnt = '0;
            end else begin
                nxt_cnt = hit ? (mcnt + 1'b1) : MW'(1);
                if (nxt_cnt == MW'(STABLE))
                    accept = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '1;
            cand   <= '1;
            stored <= '1;
            mcnt   <= '0;
            flag   <= 1'b0;
        end else begin
            if (in_slot)
                sh <= code_now[W-2:0];
            mcnt <= accept ? '0 : nxt_cnt;
            if (slot_end && differ && !hit)
                cand <= code_now;
            if (accept)
                stored <= code_now;
            if (accept)
                flag <= 1'b1;
            else if (rd_clr)
                flag <= 1'b0;
        end
    end

    AST_STORED_AT_SLOT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(stored) |-> $past(slot_end)) // R2
        else $error("accepted code changed outside its slot");

    AST_FLAG_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> !$stable(stored)) // R3
        else $error("flag rose without a new code");

    AST_ACCEPT_IS_CANDIDATE: assert property (@(posedge clk) disable iff (rst)
        ((STABLE > 1) && !$stable(stored)) |-> (stored == $past(cand))) // R4
        else $error("accepted code was not the pending candidate");

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_clr) && !$past(slot_end)) |-> !flag) // R6
        else $error("read did not clear the flag");

endmodule

// File: rtl/cim_tx_slot.sv
`timescale 1ns/1ps
module cim_tx_slot
    import cim_pkg::*;
#(
    parameter int W     = 4,
    parameter int FIRST = 26
) (
    input  slot_pos_t    tpos,
    input  logic [W-1:0] code,
    input  logic         enable,
    output logic         drive,
    output logic         bitval
);
    logic in_slot;

    always_comb begin
        in_slot = 1'b0;
        bitval  = 1'b1;
        for (int k = 0; k < W; k++) begin
            if (tpos.active && (tpos.pos == POS_W'(FIRST + k))) begin
                in_slot = 1'b1;
                bitval  = code[W-1-k];
            end
        end
        drive = in_slot && enable;
    end

endmodule

// File: rtl/cim_ci_monitor.sv
`timescale 1ns/1ps
module cim_ci_monitor
    import cim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fsync,
    input  logic             din,
    output logic             dout,
    input  logic             tic_en,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    slot_pos_t             tpos;
    logic [REG_W-1:0]      tx_reg  [NUM_CI];
    logic [CI_MAX-1:0]     rx_code [NUM_CI];
    logic [NUM_CI-1:0]     flags;
    logic [NUM_CI-1:0]     rd_clr;
    logic [NUM_CI-1:0]     drive;
    logic [NUM_CI-1:0]     bitval;
    reg_addr_e             addr;

    assign addr = reg_addr_e'(reg_addr);

    cim_frame_timer #(.FBITS(FRAME_BITS)) i_timer (
        .clk   (clk),
        .rst   (rst),
        .fsync (fsync),
        .tpos  (tpos)
    );

    for (genvar ch = 0; ch < NUM_CI; ch++) begin : g_ch
        localparam int W     = ci_width(ch);
        localparam int FIRST = ci_first(ch);
        localparam reg_addr_e RX_A = (ch == 0) ? RA_RX0 : RA_RX1;
        localparam reg_addr_e TX_A = (ch == 0) ? RA_TX0 : RA_TX1;

        logic [W-1:0] stored_w;
        logic         en_w;

        assign rd_clr[ch] = reg_rd && (addr == RX_A);

        cim_rx_filter #(.W(W), .FIRST(FIRST), .STABLE(STABLE_FRAMES)) i_rx (
            .clk    (clk),
            .rst    (rst),
            .tpos   (tpos),
            .din    (din),
            .rd_clr (rd_clr[ch]),
            .stored (stored_w),
            .flag   (flags[ch])
        );
        assign rx_code[ch] = CI_MAX'(stored_w);

        if (ch == GATED_CH) begin : g_gate
            assign en_w = !tic_en || tx_reg[ch][TX_REQ_BIT];
        end else begin : g_free
            assign en_w = 1'b1;
        end

        cim_tx_slot #(.W(W), .FIRST(FIRST)) i_tx (
            .tpos   (tpos),
            .code   (tx_reg[ch][W-1:0]),
            .enable (en_w),
            .drive  (drive[ch]),
            .bitval (bitval[ch])
        );

        always_ff @(posedge clk) begin
            if (rst)
                tx_reg[ch] <= REG_W'(ci_mask(ch));
            else if (reg_wr && (addr == TX_A))
                tx_reg[ch] <= reg_wdata;
        end
    end

    always_comb begin
        dout = 1'b1;
        for (int c = 0; c < NUM_CI; c++)
            if (drive[c])
                dout = dout & bitval[c];
    end

    always_comb begin
        unique case (addr)
            RA_RX0:  reg_rdata = REG_W'(rx_code[0]);
            RA_RX1:  reg_rdata = REG_W'(rx_code[1]);
            RA_TX0:  reg_rdata = tx_reg[0];
            default: reg_rdata = tx_reg[1];
        endcase
    end

    assign irq = |flags;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !tpos.active |-> dout) // R10
        else $error("upstream driven outside a frame");

    AST_TIC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tic_en && !tx_reg[GATED_CH][TX_REQ_BIT] && !drive[1]) |-> dout) // R9
        else $error("gated slot driven without request");

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(irq) && !$past(reg_rd)) |-> irq) // R6
        else $error("interrupt dropped without a read");

    AST_DRIVE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drive)) // R2
        else $error("two slots driven at once");

endmodule

// File: tb/test_cim_ci_monitor.sv
`timescale 1ns/1ps
module test_cim_ci_monitor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync = 1'b0;
    logic       din = 1'b1;
    logic       dout;
    logic       tic_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;

    logic [3:0] st0;
    logic [5:0] st1;
    logic [7:0] tx0;
    logic [7:0] tx1;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    cim_ci_monitor i_cim_ci_monitor (
        .clk(clk), .rst(rst), .fsync(fsync), .din(din), .dout(dout),
        .tic_en(tic_en), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic exp_up(input int b);
        if (b >= 26 && b <= 29)
            return (!tic_en || tx0[7]) ? tx0[3-(b-26)] : 1'b1;
        if (b >= 56 && b <= 61)
            return tx1[5-(b-56)];
        return 1'b1;
    endfunction

    // One 96-bit frame; checks every upstream bit.
    task automatic frame(input logic [3:0] c0, input logic [5:0] c1, input string req);
        int bad = 0;
        for (int b = 0; b < 96; b++) begin
            @(negedge clk);
            fsync = (b == 0);
            if (b >= 26 && b <= 29)      din = c0[3-(b-26)];
            else if (b >= 56 && b <= 61) din = c1[5-(b-56)];
            else                         din = b[0] ^ b[2];
            #1 if (dout !== exp_up(b)) bad++;
        end
        @(negedge clk);
        fsync = 1'b0; din = 1'b1;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic expect_irq(input logic e, input string req);
        @(negedge clk);
        #1 chk(irq === e, req, int'(irq), int'(e));
    endtask

    task automatic expect_rx(input int ch, input logic [7:0] e, input string req);
        logic [7:0] d;
        reg_read(ch[1:0], d);
        chk(d === e, req, int'(d), int'(e));
    endtask

    initial begin
        #(5ns * 150000);
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        tx0 = 8'h0F; tx1 = 8'h3F; st0 = 4'hF; st1 = 6'h3F;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_irq(1'b0, "R1 irq");
        #1 chk(dout === 1'b1, "R1 dout", int'(dout), 1);
        expect_rx(0, 8'h0F, "R1 rx0");
        expect_rx(1, 8'h3F, "R1 rx1");
        expect_rx(2, 8'h0F, "R1 tx0");
        expect_rx(3, 8'h3F, "R1 tx1");

        // R10 gap with zeros is not a frame and stays undriven
        begin
            int bad = 0;
            for (int i = 0; i < 150; i++) begin
                @(negedge clk); din = 1'b0;
                #1 if (dout !== 1'b1) bad++;
            end
            chk(bad == 0, "R10 gap dout", bad, 0);
        end
        frame(4'h0, 6'h00, "R10 frame dout");
        expect_irq(1'b0, "R10 gap not counted");
        expect_rx(0, 8'h0F, "R10 rx0 after gap");
        frame(st0, st1, "R7 cancel dout");

        // R3 sweep over all codes of subframe 0
        for (int v = 0; v < 16; v++) begin
            frame(4'(v), st1, "R2 dout");
            expect_irq(1'b0, "R3 one frame irq");
            expect_rx(0, {4'h0, st0}, "R3 one frame rx0");
            frame(4'(v), st1, "R2 dout");
            frame(4'(v), st1, "R6 extra frame dout");
            expect_irq(1'b1, "R6 sticky irq");
            expect_rx(0, 8'(v), "R3 accepted rx0");
            expect_irq(1'b0, "R6 cleared irq");
            st0 = 4'(v);
        end

        // R3 sweep over all codes of subframe 1, R5 independence
        for (int v = 0; v < 64; v++) begin
            frame(st0, 6'(v), "R2 dout");
            expect_rx(1, {2'b0, st1}, "R3 one frame rx1");
            frame(st0, 6'(v), "R2 dout");
            expect_irq(1'b1, "R5 irq from ch1");
            expect_rx(0, {4'h0, st0}, "R5 rx0 unchanged");
            expect_irq(1'b1, "R5 rx0 read keeps irq");
            expect_rx(1, 8'(v), "R3 accepted rx1");
            expect_irq(1'b0, "R6 cleared irq1");
            st1 = 6'(v);
        end

        // R4 restart
        frame(4'h5, st1, "R4 dout");
        frame(4'h9, st1, "R4 dout");
        expect_irq(1'b0, "R4 A,B no irq");
        expect_rx(0, {4'h0, st0}, "R4 A,B rx0");
        frame(4'h9, st1, "R4 dout");
        expect_rx(0, 8'h09, "R4 A,B,B rx0");
        frame(4'h2, st1, "R4 dout");
        frame(4'h4, st1, "R4 dout");
        frame(4'h2, st1, "R4 dout");
        expect_irq(1'b0, "R4 A,B,A no irq");
        expect_rx(0, 8'h09, "R4 A,B,A rx0");
        frame(4'h2, st1, "R4 dout");
        expect_rx(0, 8'h02, "R4 A,B,A,A rx0");
        st0 = 4'h2;

        // R7 revert cancels, same code never flags
        frame(4'h7, st1, "R7 dout");
        frame(4'h2, st1, "R7 dout");
        frame(4'h7, st1, "R7 dout");
        expect_irq(1'b0, "R7 revert no irq");
        expect_rx(0, 8'h02, "R7 revert rx0");
        frame(4'h7, st1, "R7 dout");
        expect_rx(0, 8'h07, "R7 accepted rx0");
        frame(4'h7, st1, "R7 dout");
        frame(4'h7, st1, "R7 dout");
        expect_irq(1'b0, "R7 same code no irq");
        st0 = 4'h7;

        // R5 both subframes change together
        frame(4'h3, 6'h15, "R5 dout");
        frame(4'h3, 6'h15, "R5 dout");
        expect_irq(1'b1, "R5 both irq");
        expect_rx(0, 8'h03, "R5 both rx0");
        expect_irq(1'b1, "R5 flag1 remains");
        expect_rx(1, 8'h15, "R5 both rx1");
        expect_irq(1'b0, "R5 both cleared");
        st0 = 4'h3; st1 = 6'h15;

        // R8 transmit sweep and readback
        for (int v = 0; v < 64; v++) begin
            tx0 = 8'(v) & 8'h7F;
            tx1 = 8'(v) ^ 8'hAA;
            reg_write(2'd2, tx0);
            reg_write(2'd3, tx1);
            frame(st0, st1, "R8 upstream code");
            reg_read(2'd2, rv);
            chk(rv === tx0, "R8 tx0 readback", int'(rv), int'(tx0));
            reg_read(2'd3, rv);
            chk(rv === tx1, "R8 tx1 readback", int'(rv), int'(tx1));
        end
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h00);
        expect_rx(0, {4'h0, st0}, "R8 rx0 write ignored");
        expect_rx(1, {2'b0, st1}, "R8 rx1 write ignored");

        // R9 request gating
        @(negedge clk); tic_en = 1'b1;
        tx0 = 8'h05; tx1 = 8'h2A;
        reg_write(2'd2, tx0);
        reg_write(2'd3, tx1);
        frame(st0, st1, "R9 gated no request");
        tx0 = 8'h85;
        reg_write(2'd2, tx0);
        frame(st0, st1, "R9 gated with request");
        tx0 = 8'h00;
        reg_write(2'd2, tx0);
        frame(st0, st1, "R9 gated zero code");
        @(negedge clk); tic_en = 1'b0;
        frame(st0, st1, "R9 ungated");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule